// File: doc/BRIEF.md
# Pointer-Chasing Prefetch Address Generator

This block lives inside a memory controller, next to the demand read path. Every demand read address is offered to it as a trigger. When the address falls inside a configured shadow window that holds linked objects, the block works out which object was touched. It then waits for that object's data block. From the data it picks out the words that hold pointers, drops any pointer that does not point into the configured virtual window of linked objects, and rebases each surviving pointer into shadow space. It issues the results as prefetch addresses toward the remapping unit, at most one per cycle, on a valid/ready port.

Two descriptor forms say where the pointers are. Offset form lists up to four byte offsets, one per descriptor byte. Mask form uses one descriptor bit per 4-byte word of the object. Both forms are turned into one word-select mask when the data block is captured. Pointers that fail the window test therefore never take an issue cycle. While a node is in flight, new triggers are held off through `trig_ready` and are never lost.

The controller has three states. `ST_IDLE` accepts triggers. A shadow hit moves it to `ST_WAIT_DATA`, and a miss leaves it in `ST_IDLE`. In `ST_WAIT_DATA`, a data beat (`blk_valid`) moves it to `ST_ISSUE` if any pointer survives, or back to `ST_IDLE` if none does. `ST_ISSUE` returns to `ST_IDLE` on the handshake that takes the last pending pointer.

Top module: `ptr_prefetch_gen`

## Requirements
- R1: A trigger accepted while `trig_ready` is high starts node processing only if `cfg_shadow_lo <= trig_addr < cfg_shadow_hi`. Any other accepted trigger is ignored: no prefetch follows, and `trig_ready` stays high.
- R2: With x = `cfg_obj_log2` (meaningful range 2..7), the object starts at `trig_addr` with its x low bits cleared. Object word w is block word ((start mod 128)/4 + w), and block word i is `blk_data[32*i+31:32*i]`.
- R3: Offset form (`cfg_mask_mode`=0): `cfg_ptr_cnt`+1 slots are used, and slot k is `cfg_desc[8k+7:8k]`. Each slot holds a byte offset inside the object, and it selects object word offset>>2; the low two bits are ignored. A slot byte of 0xFF is unused, and slots at or above the count are ignored.
- R4: Mask form (`cfg_mask_mode`=1): `cfg_desc` bit i selects the object word at byte offset 4*i.
- R5: A selected word at or beyond the object size (2^x/4 words) is never used, in either form.
- R6: A selected pointer p is kept only if `cfg_virt_lo <= p < cfg_virt_hi`. Other pointers are dropped without producing a prefetch.
- R7: Each kept pointer is issued as `pf_addr = cfg_rebase + (p - cfg_virt_lo)`, modulo 2^32.
- R8: Kept pointers are issued in ascending word order, one per `pf_valid && pf_ready` handshake. A word selected by several slots is issued once. While `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays stable.
- R9: `trig_ready` is low from the cycle after a shadow hit is accepted until the cycle after the last prefetch handshake. A trigger presented meanwhile is held, not lost. `blk_valid` has no effect while the block is idle.
- R10: After reset, `trig_ready` is 1 and `pf_valid` is 0.
- R11: If no selected pointer survives R5 and R6, the block returns to idle in the cycle after the data beat, and `pf_valid` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_shadow_lo | input | 32 | First address of the shadow window (included) |
| cfg_shadow_hi | input | 32 | End of the shadow window (excluded) |
| cfg_obj_log2 | input | 3 | log2 of the object size in bytes |
| cfg_virt_lo | input | 32 | First address of the virtual object window (included) |
| cfg_virt_hi | input | 32 | End of the virtual object window (excluded) |
| cfg_rebase | input | 32 | Shadow address that corresponds to `cfg_virt_lo` |
| cfg_desc | input | 32 | Pointer descriptor: offset bytes or word mask |
| cfg_mask_mode | input | 1 | 1 selects mask form, 0 selects offset form |
| cfg_ptr_cnt | input | 2 | Offset form: number of slots minus one |
| trig_valid | input | 1 | Demand read address is valid |
| trig_ready | output | 1 | Block can take a trigger |
| trig_addr | input | 32 | Demand read address |
| blk_valid | input | 1 | Data block for the pending node is valid |
| blk_data | input | 1024 | 128-byte data block |
| pf_valid | output | 1 | Prefetch address is valid |
| pf_ready | input | 1 | Remapping unit takes the prefetch |
| pf_addr | output | 32 | Prefetch address in shadow space |

## Verification
Some properties are checked by assertions on every cycle. A stalled prefetch keeps its address. `trig_ready` is low while prefetches are pending. Shadow hits and misses steer the controller to the right state. Each handshake retires exactly one pending pointer, and the selector never grants more than one word or a word that was not requested. The bench scenarios cover what a cycle property cannot. These are the actual address values and their ascending order for both descriptor forms, the 0xFF and count-limited slots, words past the object end, the inclusive and exclusive edges of both windows, and a trigger held across a busy period and then served.

// File: rtl/ptrpf_pkg.sv
package ptrpf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_DATA = 2'd1,
        ST_ISSUE     = 2'd2
    } ptrpf_state_e;

endpackage

// File: rtl/ptrpf_range_chk.sv
module ptrpf_range_chk #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    // half-open window test: lo is inside, hi is outside
    assign hit = (addr >= lo) && (addr < hi);
endmodule

// File: rtl/ptrpf_desc_decode.sv
module ptrpf_desc_decode #(
    parameter int WORDS     = 32,
    parameter int IDX_W     = 5,
    parameter int WORD_LOG2 = 2,
    parameter int SLOTS     = 4,
    parameter int CNT_W     = 2
) (
    input  logic [WORDS-1:0] desc,
    input  logic             mask_mode,
    input  logic [CNT_W-1:0] ptr_cnt,
    input  logic [IDX_W:0]   obj_words,
    output logic [WORDS-1:0] cand
);
    logic [SLOTS-1:0][WORDS-1:0] slot_hot;
    logic [WORDS-1:0]            offs_sel;
    logic [WORDS-1:0]            mask_sel;

    // each offset slot becomes a one-hot word select (or nothing)
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [7:0] slot_byte;
        logic       slot_used;
        assign slot_byte = desc[8*k +: 8];
        assign slot_used = (k <= int'(ptr_cnt)) && (slot_byte != 8'hFF);
        for (genvar i = 0; i < WORDS; i++) begin : g_word
            assign slot_hot[k][i] = slot_used
                                 && ((int'(slot_byte) >> WORD_LOG2) == i)
                                 && (i < int'(obj_words));
        end
    end

    always_comb begin
        offs_sel = '0;
        for (int k = 0; k < SLOTS; k++) begin
            offs_sel = offs_sel | slot_hot[k];
        end
    end

    // mask form: bit i picks word i, clipped to the object size
    for (genvar i = 0; i < WORDS; i++) begin : g_mask
        assign mask_sel[i] = desc[i] && (i < int'(obj_words));
    end

    assign cand = mask_mode ? mask_sel : offs_sel;
endmodule

// File: rtl/ptrpf_lowest_pick.sv
module ptrpf_lowest_pick #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign grant = req & (~req + 1'b1);
    assign any   = |req;

    // R8: one word per cycle, and never a word nobody asked for
    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r8_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
endmodule

// File: rtl/ptr_prefetch_gen.sv
module ptr_prefetch_gen
    import ptrpf_pkg::*;
#(
    parameter  int PTR_W     = 32,
    parameter  int BLK_LOG2  = 7,
    localparam int WORD_LOG2 = $clog2(PTR_W / 8),
    localparam int IDX_W     = BLK_LOG2 - WORD_LOG2,
    localparam int BLK_WORDS = 1 << IDX_W,
    localparam int SLOTS     = BLK_WORDS / 8,
    localparam int CNT_W     = $clog2(SLOTS),
    localparam int LOG2_W    = $clog2(BLK_LOG2 + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PTR_W-1:0]           cfg_shadow_lo,
    input  logic [PTR_W-1:0]           cfg_shadow_hi,
    input  logic [LOG2_W-1:0]          cfg_obj_log2,
    input  logic [PTR_W-1:0]           cfg_virt_lo,
    input  logic [PTR_W-1:0]           cfg_virt_hi,
    input  logic [PTR_W-1:0]           cfg_rebase,
    input  logic [BLK_WORDS-1:0]       cfg_desc,
    input  logic                       cfg_mask_mode,
    input  logic [CNT_W-1:0]           cfg_ptr_cnt,
    input  logic                       trig_valid,
    output logic                       trig_ready,
    input  logic [PTR_W-1:0]           trig_addr,
    input  logic                       blk_valid,
    input  logic [BLK_WORDS*PTR_W-1:0] blk_data,
    output logic                       pf_valid,
    input  logic                       pf_ready,
    output logic [PTR_W-1:0]           pf_addr
);
    ptrpf_state_e state_q, state_d;

    logic [LOG2_W-1:0]          eff_log2;
    logic [IDX_W:0]             obj_words;
    logic [IDX_W-1:0]           off_mask;
    logic [IDX_W-1:0]           obj_word_d;
    logic [IDX_W-1:0]           obj_word_q;
    logic                       shadow_hit;
    logic [BLK_WORDS-1:0]       cand_obj;
    logic [BLK_WORDS-1:0]       cand_blk;
    logic [BLK_WORDS-1:0]       virt_hit;
    logic [BLK_WORDS-1:0]       live_mask;
    logic [BLK_WORDS-1:0]       pend_q;
    logic [BLK_WORDS-1:0]       grant;
    logic [IDX_W-1:0]           sel_idx;
    logic                       pend_any;
    logic [BLK_WORDS*PTR_W-1:0] data_q;
    logic [PTR_W-1:0]           sel_ptr;
    logic                       pf_fire;

    // object size clamped to [one word, one block]
    always_comb begin
        if (cfg_obj_log2 < LOG2_W'(WORD_LOG2))      eff_log2 = LOG2_W'(WORD_LOG2);
        else if (cfg_obj_log2 > LOG2_W'(BLK_LOG2))  eff_log2 = LOG2_W'(BLK_LOG2);
        else                                        eff_log2 = cfg_obj_log2;
    end

    assign obj_words  = (IDX_W + 1)'(1) << (eff_log2 - LOG2_W'(WORD_LOG2));
    assign off_mask   = IDX_W'(obj_words - 1'b1);
    assign obj_word_d = trig_addr[BLK_LOG2-1:WORD_LOG2] & ~off_mask;

    ptrpf_range_chk #(.W(PTR_W)) u_shadow_chk (
        .addr (trig_addr),
        .lo   (cfg_shadow_lo),
        .hi   (cfg_shadow_hi),
        .hit  (shadow_hit)
    );

    ptrpf_desc_decode #(
        .WORDS     (BLK_WORDS),
        .IDX_W     (IDX_W),
        .WORD_LOG2 (WORD_LOG2),
        .SLOTS     (SLOTS),
        .CNT_W     (CNT_W)
    ) u_decode (
        .desc      (cfg_desc),
        .mask_mode (cfg_mask_mode),
        .ptr_cnt   (cfg_ptr_cnt),
        .obj_words (obj_words),
        .cand      (cand_obj)
    );

    // object words mapped onto block words; object is size-aligned so no wrap
    assign cand_blk = cand_obj << obj_word_q;

    for (genvar i = 0; i < BLK_WORDS; i++) begin : g_virt
        ptrpf_range_chk #(.W(PTR_W)) u_virt_chk (
            .addr (blk_data[i*PTR_W +: PTR_W]),
            .lo   (cfg_virt_lo),
            .hi   (cfg_virt_hi),
            .hit  (virt_hit[i])
        );
    end

    assign live_mask = cand_blk & virt_hit;

    ptrpf_lowest_pick #(.N(BLK_WORDS), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pend_q),
        .grant (grant),
        .idx   (sel_idx),
        .any   (pend_any)
    );

    assign pf_fire = (state_q == ST_ISSUE) && pf_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_valid && shadow_hit) state_d = ST_WAIT_DATA;
            end
            ST_WAIT_DATA: begin
                if (blk_valid) state_d = (|live_mask) ? ST_ISSUE : ST_IDLE;
            end
            ST_ISSUE: begin
                if (pf_ready && ((pend_q & ~grant) == '0)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // node datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obj_word_q <= '0;
            data_q     <= '0;
            pend_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && trig_valid && shadow_hit) begin
                obj_word_q <= obj_word_d;
            end
            if (state_q == ST_WAIT_DATA && blk_valid) begin
                data_q <= blk_data;
                pend_q <= live_mask;
            end else if (pf_fire) begin
                pend_q <= pend_q & ~grant;
            end
        end
    end

    assign sel_ptr = data_q[sel_idx*PTR_W +: PTR_W];

    // outputs
    always_comb begin
        trig_ready = (state_q == ST_IDLE);
        pf_valid   = (state_q == ST_ISSUE);
        pf_addr    = cfg_rebase + (sel_ptr - cfg_virt_lo);
    end

    // R8: a stalled prefetch keeps its address
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));
    // R8: each handshake retires exactly one pending pointer
    a_r8_one_retire: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready |=> $countones(pend_q) == $countones($past(pend_q)) - 1);
    // R8: issuing always has something to issue
    a_r8_issue_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> pend_any);
    // R9: no new trigger while prefetches are pending
    a_r9_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !trig_ready);
    // R1: a shadow hit closes the trigger port next cycle
    a_r1_hit_engages: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && trig_ready && shadow_hit |=> !trig_ready);
    // R1: a miss leaves the block idle
    a_r1_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid && trig_ready && !shadow_hit |=> trig_ready && !pf_valid);
endmodule

// File: tb/ptr_prefetch_gen_test.sv
module ptr_prefetch_gen_test;
    localparam int BB = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     cfg_shadow_lo = 32'h8000_0000;
    logic [31:0]     cfg_shadow_hi = 32'h8001_0000;
    logic [2:0]      cfg_obj_log2 = 3'd4;
    logic [31:0]     cfg_virt_lo = 32'h1000_0000;
    logic [31:0]     cfg_virt_hi = 32'h1010_0000;
    logic [31:0]     cfg_rebase = 32'h8000_0000;
    logic [31:0]     cfg_desc = '0;
    logic            cfg_mask_mode = 1'b0;
    logic [1:0]      cfg_ptr_cnt = '0;
    logic            trig_valid = 1'b0;
    logic            trig_ready;
    logic [31:0]     trig_addr = '0;
    logic            blk_valid = 1'b0;
    logic [BB-1:0]   blk_data = '0;
    logic            pf_valid;
    logic            pf_ready = 1'b0;
    logic [31:0]     pf_addr;

    int checks = 0;
    int errors = 0;
    int exp_n;
    logic [31:0] exp_a [32];

    always #4 clk = ~clk;

    ptr_prefetch_gen uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_shadow_lo(cfg_shadow_lo), .cfg_shadow_hi(cfg_shadow_hi),
        .cfg_obj_log2(cfg_obj_log2), .cfg_virt_lo(cfg_virt_lo),
        .cfg_virt_hi(cfg_virt_hi), .cfg_rebase(cfg_rebase),
        .cfg_desc(cfg_desc), .cfg_mask_mode(cfg_mask_mode),
        .cfg_ptr_cnt(cfg_ptr_cnt),
        .trig_valid(trig_valid), .trig_ready(trig_ready), .trig_addr(trig_addr),
        .blk_valid(blk_valid), .blk_data(blk_data),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_shadow(input logic [31:0] a);
        return (a >= cfg_shadow_lo) && (a < cfg_shadow_hi);
    endfunction

    // expected prefetch list from R2..R8
    function automatic void calc_expect(input logic [31:0] addr, input logic [BB-1:0] d);
        int x, nw, base_w;
        logic [31:0] start, p;
        x = int'(cfg_obj_log2);
        if (x < 2) x = 2;
        if (x > 7) x = 7;
        nw = (1 << x) / 4;
        start = addr & ~((32'd1 << x) - 1);
        base_w = int'(start % 128) / 4;
        exp_n = 0;
        for (int w = 0; w < nw; w++) begin
            bit sel = 1'b0;
            if (cfg_mask_mode) sel = cfg_desc[w];
            else begin
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] b = cfg_desc[8*k +: 8];
                    if (k <= int'(cfg_ptr_cnt) && b != 8'hFF && (int'(b) / 4) == w) sel = 1'b1;
                end
            end
            if (sel) begin
                p = d[32*(base_w + w) +: 32];
                if (p >= cfg_virt_lo && p < cfg_virt_hi) begin
                    exp_a[exp_n] = cfg_rebase + (p - cfg_virt_lo);
                    exp_n++;
                end
            end
        end
    endfunction

    function automatic logic [BB-1:0] rand_block(input int in_pct);
        logic [BB-1:0] d;
        for (int i = 0; i < 32; i++) begin
            if ($urandom_range(99) < in_pct)
                d[32*i +: 32] = cfg_virt_lo + ($urandom % (cfg_virt_hi - cfg_virt_lo));
            else
                d[32*i +: 32] = 32'h2000_0000 + $urandom_range(32'h00FF_FFFF);
        end
        return d;
    endfunction

    task automatic send_trig(input logic [31:0] a, input string req);
        @(negedge clk);
        chk(trig_ready === 1'b1, req, {31'd0, trig_ready}, 32'd1);
        trig_addr = a;
        trig_valid = 1'b1;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic feed(input logic [BB-1:0] d);
        blk_data = d;
        blk_valid = 1'b1;
        @(negedge clk);
        blk_valid = 1'b0;
    endtask

    task automatic drain(input int stall_pct, input string req);
        int idx = 0;
        int guard = 0;
        while (idx < exp_n && guard < 3000) begin
            pf_ready = ($urandom_range(99) >= stall_pct);
            if (!pf_valid) begin
                chk(1'b0, req, 32'd0, 32'd1);
            end else if (pf_ready) begin
                chk(pf_addr === exp_a[idx], req, pf_addr, exp_a[idx]);
                idx++;
            end
            @(negedge clk);
            guard++;
        end
        pf_ready = 1'b0;
        chk(idx == exp_n, req, idx, exp_n);
        // R9 R11: idle again, nothing extra issued
        chk(pf_valid === 1'b0 && trig_ready === 1'b1, "R9", {30'd0, pf_valid, trig_ready}, 32'd1);
    endtask

    task automatic node(input logic [31:0] a, input logic [BB-1:0] d,
                        input int stall_pct, input string req);
        send_trig(a, "R9");
        if (!in_shadow(a)) begin
            // R1: ignored trigger, still idle
            chk(trig_ready === 1'b1 && pf_valid === 1'b0, "R1", {30'd0, pf_valid, trig_ready}, 32'd1);
            return;
        end
        chk(trig_ready === 1'b0, "R1", {31'd0, trig_ready}, 32'd0);
        calc_expect(a, d);
        feed(d);
        drain(stall_pct, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [BB-1:0] d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(trig_ready === 1'b1, "R10", {31'd0, trig_ready}, 32'd1);
        chk(pf_valid === 1'b0, "R10", {31'd0, pf_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 window edges
        d = rand_block(100);
        cfg_mask_mode = 1'b1; cfg_desc = 32'hF; cfg_obj_log2 = 3'd4;
        node(cfg_shadow_hi, d, 0, "R1");
        node(cfg_shadow_lo - 1, d, 0, "R1");
        node(cfg_shadow_lo, d, 0, "R1");

        // R9 blk_valid in idle has no effect
        feed(d);
        chk(pf_valid === 1'b0 && trig_ready === 1'b1, "R9", {30'd0, pf_valid, trig_ready}, 32'd1);

        // R3 offset slots with an unused 0xFF slot, object at word 12
        cfg_mask_mode = 1'b0; cfg_obj_log2 = 3'd4; cfg_ptr_cnt = 2'd3;
        cfg_desc = 32'h04FF_0C00;
        d = rand_block(100);
        node(cfg_shadow_lo + 32'h35, d, 30, "R3");
        chk(exp_n == 3, "R3", exp_n, 3);

        // R5 offset past a two-word object; R3 count limits slots
        cfg_obj_log2 = 3'd3; cfg_ptr_cnt = 2'd1; cfg_desc = 32'h0000_0408;
        node(cfg_shadow_lo + 32'h18, d, 0, "R5");
        chk(exp_n == 1, "R5", exp_n, 1);

        // R8 duplicate offsets in one word give one prefetch
        cfg_obj_log2 = 3'd5; cfg_ptr_cnt = 2'd2; cfg_desc = 32'h0006_0404;
        node(cfg_shadow_lo + 32'h40, d, 0, "R8");
        chk(exp_n == 1, "R8", exp_n, 1);

        // R4 full mask over 128-byte object, with stalls
        cfg_mask_mode = 1'b1; cfg_obj_log2 = 3'd7; cfg_desc = 32'hFFFF_FFFF;
        node(cfg_shadow_lo + 32'h7F, d, 50, "R4");
        chk(exp_n == 32, "R4", exp_n, 32);

        // R5 mask bits past a 32-byte object
        cfg_obj_log2 = 3'd5; cfg_desc = 32'hFFFF_FF0F;
        node(cfg_shadow_lo + 32'h60, d, 20, "R5");
        chk(exp_n == 4, "R5", exp_n, 4);

        // R6 R7 virtual window edges
        cfg_obj_log2 = 3'd4; cfg_desc = 32'hF;
        d = '0;
        d[31:0] = cfg_virt_lo; d[63:32] = cfg_virt_hi;
        d[95:64] = cfg_virt_hi - 1; d[127:96] = cfg_virt_lo - 1;
        node(cfg_shadow_lo, d, 0, "R7");
        chk(exp_n == 2 && exp_a[0] == cfg_rebase
            && exp_a[1] == cfg_rebase + (cfg_virt_hi - cfg_virt_lo - 1),
            "R6", exp_n, 2);

        // R11 nothing survives
        d = rand_block(0);
        node(cfg_shadow_lo + 32'h100, d, 0, "R11");

        // R9 trigger held during issue then served
        d = rand_block(100);
        cfg_desc = 32'h5;
        send_trig(cfg_shadow_lo + 32'h200, "R9");
        calc_expect(cfg_shadow_lo + 32'h200, d);
        feed(d);
        trig_addr = cfg_shadow_lo + 32'h310; trig_valid = 1'b1; pf_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(trig_ready === 1'b0 && pf_valid === 1'b1, "R9", {30'd0, pf_valid, trig_ready}, 32'd2);
            @(negedge clk);
        end
        drain(0, "R9");
        @(negedge clk);
        trig_valid = 1'b0;
        chk(trig_ready === 1'b0, "R9", {31'd0, trig_ready}, 32'd0);
        d = rand_block(100);
        calc_expect(cfg_shadow_lo + 32'h310, d);
        feed(d);
        drain(10, "R9");

        // random mix covering R2..R8
        for (int t = 0; t < 80; t++) begin
            logic [31:0] a;
            cfg_mask_mode = 1'($urandom_range(1));
            cfg_obj_log2 = 3'($urandom_range(7, 2));
            cfg_ptr_cnt = 2'($urandom_range(3));
            if (cfg_mask_mode) cfg_desc = $urandom;
            else begin
                for (int k = 0; k < 4; k++)
                    cfg_desc[8*k +: 8] = ($urandom_range(3) == 0) ? 8'hFF : 8'($urandom_range(127));
            end
            if ($urandom_range(4) == 0) a = $urandom;
            else a = cfg_shadow_lo + $urandom_range(32'hFFFF);
            node(a, rand_block(50), 30, "R2");
        end

        finish_run();
    end
endmodule